// File: doc/BRIEF.md
# Auto-Incrementing Transfer Data Buffer

This block is the staging store between a host register bus and a serial flash sequencer. It holds 512 bytes as 128 words of 32 bits. The host does not see the storage as a flat window. It reaches every word through one 32-bit data port. A small control register chooses whether that port fills the store or drains it, turns automatic pointer advance on or off, and holds the host's word pointer.

The sequencer has a separate pointer that software clears before each transfer. It takes outgoing payload words from the store and writes received words into it, with per-byte lane enables so that a trailing partial word lands in the low-order lanes. Host and sequencer share one storage port. The sequencer always wins a same-cycle conflict, and the host is held off with a ready signal until the port is free.

Top module: `xfer_dbuf`

## Requirements
- R1: The store holds 128 words of 32 bits. The host pointer and the sequencer pointer each wrap from 127 to 0 when they advance.
- R2: A write to the control register loads the direction from bit 9, auto-advance from bit 8 and the host pointer from bits 7:0, taken modulo 128. A write that carries only mode bits therefore sets the pointer to 0. `host_ctrl_rdata` returns direction in bit 9, auto-advance in bit 8 and the pointer in bits 6:0, with every other bit at 0.
- R3: With direction 1 (fill), a granted host data access writes `host_data_wdata` into the word at the host pointer.
- R4: With direction 0 (drain), a granted host data access places the word at the host pointer on `host_rdata` one cycle after the grant edge. `host_rdata` holds its value until the next granted drain access.
- R5: With auto-advance 1, each granted host data access moves the host pointer forward by one. With auto-advance 0, the pointer does not change.
- R6: While `seq_req` is high, `host_ready` is low and no host access takes place, so the host pointer and `host_rdata` stay unchanged. A held `host_req` is served in the first cycle in which `seq_req` is low.
- R7: `seq_ptr_clr` sets the sequencer pointer to 0. If `seq_req` is high in the same cycle, that access uses word 0 and the pointer afterwards reads 1.
- R8: A sequencer access with `seq_we` at 1 writes the byte lanes of `seq_wdata` whose `seq_be` bit is set, where lane k is bits 8k+7:8k. A sequencer access with `seq_we` at 0 puts the addressed word on `seq_rdata` one cycle later, and `seq_rdata` holds until the next sequencer read. Every sequencer access advances its pointer by one.
- R9: A trailing partial word of r bytes (r = 1 to 3) uses lanes 0 to r-1, in little-endian order. Written with only those lanes enabled, it leaves the upper lanes of the stored word unchanged.
- R10: When a control write and a granted host data access occur in the same cycle, the access uses the old direction and pointer, and the pointer then takes the written value.
- R11: After reset, both pointers, the direction, auto-advance, `host_rdata` and `seq_rdata` are all 0, and `host_ready` is 1 while `seq_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_ctrl_we | input | 1 | Write strobe for the control register |
| host_ctrl_wdata | input | 32 | Control write value: direction, auto-advance, pointer |
| host_ctrl_rdata | output | 32 | Control register read-back |
| host_req | input | 1 | Host data port access request |
| host_data_wdata | input | 32 | Word written on a fill access |
| host_ready | output | 1 | Host access is granted in this cycle |
| host_rdata | output | 32 | Word returned by the last drain access |
| seq_ptr_clr | input | 1 | Clear the sequencer pointer |
| seq_req | input | 1 | Sequencer access request (takes priority) |
| seq_we | input | 1 | 1: sequencer writes received data, 0: reads payload |
| seq_be | input | 4 | Byte lane enables for sequencer writes |
| seq_wdata | input | 32 | Received word from the sequencer |
| seq_rdata | output | 32 | Payload word read by the sequencer |

## Verification
The embedded assertions check pointer behaviour on every cycle. They cover the step by one under auto-advance, the wrap from 127 to 0, the host pointer holding while the host is stalled or idle, and the effect of a sequencer pointer clear with and without a same-cycle access. They also check that both read-data outputs hold between their own read grants. Only the bench scenarios show stored contents: data written through one side and read back through the other, byte-lane merging of a partial trailing word, pointer loads modulo 128, and the order of a control write against a same-cycle data access. The bench checks these against a model of the storage.

// File: rtl/xfer_dbuf_pkg.sv
package xfer_dbuf_pkg;

  // Next pointer value with wrap at the word count.
  function automatic int unsigned wrap_inc(input int unsigned p, input int unsigned words);
    return (p + 1 >= words) ? 0 : p + 1;
  endfunction

endpackage

// File: rtl/xfer_dbuf_hostreg.sv
module xfer_dbuf_hostreg #(
  parameter int WORDS = 128,
  parameter int PW    = 8,
  parameter int DW    = 32,
  localparam int IW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctrl_we,
  input  logic [DW-1:0] ctrl_wdata,
  input  logic          access,
  output logic          dir_o,
  output logic          autoinc_o,
  output logic [IW-1:0] ptr_o,
  output logic [DW-1:0] ctrl_rdata
);
  import xfer_dbuf_pkg::*;

  localparam int DIR_BIT  = PW + 1;
  localparam int AUTO_BIT = PW;

  logic          dir_q, autoinc_q;
  logic [IW-1:0] ptr_q;
  logic          advance;
  logic [IW-1:0] ptr_next;

  assign advance  = access && autoinc_q && !ctrl_we;
  assign ptr_next = IW'(wrap_inc(int'(ptr_q), WORDS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q     <= 1'b0;
      autoinc_q <= 1'b0;
      ptr_q     <= '0;
    end else if (ctrl_we) begin
      dir_q     <= ctrl_wdata[DIR_BIT];
      autoinc_q <= ctrl_wdata[AUTO_BIT];
      ptr_q     <= ctrl_wdata[IW-1:0];
    end else if (advance) begin
      ptr_q <= ptr_next;
    end
  end

  always_comb begin
    ctrl_rdata           = '0;
    ctrl_rdata[DIR_BIT]  = dir_q;
    ctrl_rdata[AUTO_BIT] = autoinc_q;
    ctrl_rdata[IW-1:0]   = ptr_q;
  end

  assign dir_o     = dir_q;
  assign autoinc_o = autoinc_q;
  assign ptr_o     = ptr_q;

  assert_ptr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> (ptr_q == IW'(wrap_inc(int'($past(ptr_q)), WORDS))));

  assert_ptr_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && ptr_q == IW'(WORDS - 1)) |=> (ptr_q == '0));

  assert_ptr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!access && !ctrl_we) |=> $stable(ptr_q));

endmodule

// File: rtl/xfer_dbuf_seqptr.sv
module xfer_dbuf_seqptr #(
  parameter int WORDS = 128,
  localparam int IW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          req,
  output logic [IW-1:0] idx_o
);
  import xfer_dbuf_pkg::*;

  logic [IW-1:0] ptr_q;

  assign idx_o = clr ? '0 : ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (req)    ptr_q <= IW'(wrap_inc(int'(idx_o), WORDS));
    else if (clr)    ptr_q <= '0;
  end

  assert_clr_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !req) |=> (ptr_q == '0));

  assert_clr_access_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && req) |=> (ptr_q == IW'(1)));

endmodule

// File: rtl/xfer_dbuf_mem.sv
module xfer_dbuf_mem #(
  parameter int WORDS = 128,
  parameter int DW    = 32,
  localparam int IW   = $clog2(WORDS),
  localparam int NB   = DW / 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] idx,
  input  logic [NB-1:0] be,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rword
);
  logic [DW-1:0] store [WORDS];

  assign rword = store[idx];

  for (genvar k = 0; k < NB; k++) begin : g_lane
    always_ff @(posedge clk) begin
      if (we && be[k]) store[idx][8*k +: 8] <= wdata[8*k +: 8];
    end
  end

endmodule

// File: rtl/xfer_dbuf.sv
module xfer_dbuf #(
  parameter int WORDS = 128,
  parameter int PW    = 8,
  parameter int DW    = 32,
  localparam int IW   = $clog2(WORDS),
  localparam int NB   = DW / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_ctrl_we,
  input  logic [DW-1:0] host_ctrl_wdata,
  output logic [DW-1:0] host_ctrl_rdata,
  input  logic          host_req,
  input  logic [DW-1:0] host_data_wdata,
  output logic          host_ready,
  output logic [DW-1:0] host_rdata,
  input  logic          seq_ptr_clr,
  input  logic          seq_req,
  input  logic          seq_we,
  input  logic [NB-1:0] seq_be,
  input  logic [DW-1:0] seq_wdata,
  output logic [DW-1:0] seq_rdata
);
  logic          host_dir, host_auto;
  logic [IW-1:0] host_ptr, seq_idx;
  logic          host_grant, host_fill, host_drain, seq_read;
  logic          mem_we;
  logic [IW-1:0] mem_idx;
  logic [NB-1:0] mem_be;
  logic [DW-1:0] mem_wdata, mem_rword;
  logic [DW-1:0] host_rdata_q, seq_rdata_q;

  // Arbitration: sequencer first, host waits.
  assign host_ready = !seq_req;
  assign host_grant = host_req && host_ready;
  assign host_fill  = host_grant && host_dir;
  assign host_drain = host_grant && !host_dir;
  assign seq_read   = seq_req && !seq_we;

  xfer_dbuf_hostreg #(.WORDS(WORDS), .PW(PW), .DW(DW)) u_hostreg (
    .clk(clk), .rst_n(rst_n),
    .ctrl_we(host_ctrl_we), .ctrl_wdata(host_ctrl_wdata),
    .access(host_grant),
    .dir_o(host_dir), .autoinc_o(host_auto), .ptr_o(host_ptr),
    .ctrl_rdata(host_ctrl_rdata)
  );

  xfer_dbuf_seqptr #(.WORDS(WORDS)) u_seqptr (
    .clk(clk), .rst_n(rst_n),
    .clr(seq_ptr_clr), .req(seq_req), .idx_o(seq_idx)
  );

  assign mem_idx   = seq_req ? seq_idx   : host_ptr;
  assign mem_we    = seq_req ? seq_we    : host_fill;
  assign mem_be    = seq_req ? seq_be    : '1;
  assign mem_wdata = seq_req ? seq_wdata : host_data_wdata;

  xfer_dbuf_mem #(.WORDS(WORDS), .DW(DW)) u_mem (
    .clk(clk), .we(mem_we), .idx(mem_idx), .be(mem_be),
    .wdata(mem_wdata), .rword(mem_rword)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_rdata_q <= '0;
      seq_rdata_q  <= '0;
    end else begin
      if (host_drain) host_rdata_q <= mem_rword;
      if (seq_read)   seq_rdata_q  <= mem_rword;
    end
  end

  assign host_rdata = host_rdata_q;
  assign seq_rdata  = seq_rdata_q;

  assert_hrd_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !host_drain |=> $stable(host_rdata));

  assert_srd_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_read |=> $stable(seq_rdata));

  assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_req && host_req) |=> $stable(host_rdata));

endmodule

// File: tb/xfer_dbuf_bench.sv
module xfer_dbuf_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_ctrl_we = 1'b0;
  logic [31:0] host_ctrl_wdata = '0;
  logic [31:0] host_ctrl_rdata;
  logic        host_req = 1'b0;
  logic [31:0] host_data_wdata = '0;
  logic        host_ready;
  logic [31:0] host_rdata;
  logic        seq_ptr_clr = 1'b0;
  logic        seq_req = 1'b0;
  logic        seq_we = 1'b0;
  logic [3:0]  seq_be = '0;
  logic [31:0] seq_wdata = '0;
  logic [31:0] seq_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Model state
  logic [31:0] m_mem [128];
  bit          m_dir, m_auto;
  int          m_hptr, m_sptr;
  logic [31:0] m_hrd, m_srd;

  always #10 clk = ~clk;

  xfer_dbuf u_xfer_dbuf (
    .clk(clk), .rst_n(rst_n),
    .host_ctrl_we(host_ctrl_we), .host_ctrl_wdata(host_ctrl_wdata),
    .host_ctrl_rdata(host_ctrl_rdata),
    .host_req(host_req), .host_data_wdata(host_data_wdata),
    .host_ready(host_ready), .host_rdata(host_rdata),
    .seq_ptr_clr(seq_ptr_clr), .seq_req(seq_req), .seq_we(seq_we),
    .seq_be(seq_be), .seq_wdata(seq_wdata), .seq_rdata(seq_rdata)
  );

  function automatic int f_next(input int p);
    return (p == 127) ? 0 : p + 1;
  endfunction

  function automatic logic [31:0] f_merge(input logic [31:0] old, input logic [31:0] nw,
                                          input logic [3:0] be);
    logic [31:0] r = old;
    for (int k = 0; k < 4; k++) if (be[k]) r[8*k +: 8] = nw[8*k +: 8];
    return r;
  endfunction

  function automatic logic [31:0] f_ctrl(input bit d, input bit a, input int p);
    return {22'd0, d, a, 1'b0, p[6:0]};
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // One clock cycle: drive, check ready, update model at the edge, compare.
  task automatic cyc(input string tag, input bit hreq, input bit cwe, input logic [31:0] cd,
                     input logic [31:0] hwd, input bit sreq, input bit swe, input bit sclr,
                     input logic [3:0] sbe, input logic [31:0] swd);
    int sidx;
    bit hgrant;
    host_req = hreq; host_ctrl_we = cwe; host_ctrl_wdata = cd; host_data_wdata = hwd;
    seq_req = sreq; seq_we = swe; seq_ptr_clr = sclr; seq_be = sbe; seq_wdata = swd;
    #1;
    chk(tag, "host_ready", {31'd0, host_ready}, {31'd0, !sreq});
    @(posedge clk);
    hgrant = hreq && !sreq;
    if (sreq) begin
      sidx = sclr ? 0 : m_sptr;
      if (swe) m_mem[sidx] = f_merge(m_mem[sidx], swd, sbe);
      else     m_srd = m_mem[sidx];
      m_sptr = f_next(sidx);
    end else if (sclr) begin
      m_sptr = 0;
    end
    if (hgrant) begin
      if (m_dir) m_mem[m_hptr] = hwd;
      else       m_hrd = m_mem[m_hptr];
    end
    if (cwe) begin
      m_dir = cd[9]; m_auto = cd[8]; m_hptr = int'(cd[6:0]);
    end else if (hgrant && m_auto) begin
      m_hptr = f_next(m_hptr);
    end
    @(negedge clk);
    chk(tag, "host_rdata", host_rdata, m_hrd);
    chk(tag, "seq_rdata", seq_rdata, m_srd);
    chk(tag, "host_ctrl_rdata", host_ctrl_rdata, f_ctrl(m_dir, m_auto, m_hptr));
  endtask

  task automatic idle(input string tag);
    cyc(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog run did not finish actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    m_dir = 0; m_auto = 0; m_hptr = 0; m_sptr = 0; m_hrd = '0; m_srd = '0;
    for (int i = 0; i < 128; i++) m_mem[i] = '0;
    void'($urandom(32'h1357_2468));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11: reset state
    chk("R11", "host_rdata", host_rdata, 32'h0);
    chk("R11", "seq_rdata", seq_rdata, 32'h0);
    chk("R11", "host_ctrl_rdata", host_ctrl_rdata, 32'h0);
    chk("R11", "host_ready", {31'd0, host_ready}, 32'd1);

    // R2/R3: fill mode, auto, pointer 0; fill all 128 words (R1 wraps to 0)
    cyc("R2", 0, 1, 32'h300, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 128; i++)
      cyc("R3", 1, 0, 0, 32'hA500_0000 + 32'(i * 7), 0, 0, 0, 0, 0);
    chk("R1", "ptr after 128 fills", host_ctrl_rdata, 32'h300);

    // R4/R5: drain with auto from word 0
    cyc("R2", 0, 1, 32'h100, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 4; i++) cyc("R4", 1, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R4", "host_rdata word3", host_rdata, 32'hA500_0015);
    idle("R4");

    // R5: auto off keeps pointer, word 5 read twice
    cyc("R5", 0, 1, 32'h005, 0, 0, 0, 0, 0, 0);
    cyc("R5", 1, 0, 0, 0, 0, 0, 0, 0, 0);
    cyc("R5", 1, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R5", "ctrl ptr held", host_ctrl_rdata, 32'h005);

    // R2: pointer loaded modulo 128 (200 -> 72)
    cyc("R2", 0, 1, 32'h1C8, 0, 0, 0, 0, 0, 0);
    chk("R2", "ctrl modulo", host_ctrl_rdata, 32'h148);

    // R1: host pointer wrap from 127
    cyc("R1", 0, 1, 32'h17F, 0, 0, 0, 0, 0, 0);
    cyc("R1", 1, 0, 0, 0, 0, 0, 0, 0, 0);
    cyc("R1", 1, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R1", "read after wrap", host_rdata, 32'hA500_0000);

    // R7/R8: sequencer clear and read
    cyc("R7", 0, 0, 0, 0, 0, 0, 1, 0, 0);
    cyc("R8", 0, 0, 0, 0, 1, 0, 0, 0, 0);
    cyc("R8", 0, 0, 0, 0, 1, 0, 0, 0, 0);
    chk("R8", "seq_rdata word1", seq_rdata, 32'hA500_0007);
    cyc("R7", 0, 0, 0, 0, 1, 0, 1, 0, 0);
    chk("R7", "clr+read word0", seq_rdata, 32'hA500_0000);

    // R9: partial trailing word, 2 bytes in lanes 0..1 over word 1
    cyc("R9", 0, 0, 0, 0, 1, 1, 0, 4'b0011, 32'hFFFF_BBAA);
    cyc("R9", 0, 1, 32'h101, 0, 0, 0, 0, 0, 0);
    cyc("R9", 1, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R9", "merged word", host_rdata, 32'hA500_BBAA);

    // R6: conflict, host stalled then served
    cyc("R6", 0, 1, 32'h10A, 0, 0, 0, 0, 0, 0);
    cyc("R6", 1, 0, 0, 0, 1, 0, 1, 0, 0);
    chk("R6", "ptr held in stall", host_ctrl_rdata, 32'h10A);
    cyc("R6", 1, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R6", "served after stall", host_rdata, 32'hA500_0046);

    // R10: control write with same-cycle access
    cyc("R10", 1, 1, 32'h314, 0, 0, 0, 0, 0, 0);
    chk("R10", "old ptr used", host_rdata, 32'hA500_004D);
    chk("R10", "ptr takes written", host_ctrl_rdata, 32'h314);

    // Constrained random mix
    for (int n = 0; n < 4000; n++) begin
      bit cwe = ($urandom % 16) == 0;
      logic [31:0] cd = {22'd0, 10'($urandom)};
      bit hreq = $urandom % 2;
      bit sreq = ($urandom % 10) < 3;
      bit sclr = ($urandom % 16) == 0;
      bit swe = $urandom % 2;
      logic [3:0] sbe = 4'($urandom);
      cyc("R8", hreq, cwe, cd, $urandom, sreq, swe, sclr, sbe, $urandom);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule